// File: doc/BRIEF.md
# Keep-Alive Watchdog Timer with Two-Step Commands

This block is a down-counting watchdog for a processor subsystem. Software starts it, and later keeps it alive, by writing a two-word start sequence to the control register: an arm word, then the start word. Each full start sequence loads the counter with the configured full-scale value. The counter then decrements on every cycle in which the tick input is high. Stopping the watchdog takes the same kind of pair, made of a stop arm word and then the stop word. A single stray write therefore cannot start or stop the counter.

When the enabled counter sits at zero and a tick arrives, the watchdog expires. It drops back to the disabled state and drives a fixed-length reset pulse on one of two outputs, as chosen by an action register: a local core reset or a bus-wide reset that clears every core on the bus. It also sets a sticky cause flag. The block's power-on reset is separate from the pulse it produces, so software can read the flag after the reboot and clear it by writing 1. A build-time option gives the stop sequence the same arm word as the start sequence. In that variant a running watchdog can no longer be stopped.

Top module: `keepalive_wdog`

## Requirements
- R1: After power-on reset the counter reads 0, the watchdog is disabled, no command is armed, the action and cause fields are 0, and both reset outputs are low.
- R2: A control write (address 0) of the start arm word 0x0000A5E1, followed directly by a control write of the start word 0x00005AE1, enables the watchdog and loads the counter with LOAD_VAL. This takes effect on the clock edge that captures the second write.
- R3: While enabled, the counter drops by one on each clock edge where tick is high, and it holds its value when tick is low.
- R4: Repeating the start sequence while the watchdog runs reloads the counter to LOAD_VAL. This is the keep-alive.
- R5: A control write of the stop arm word 0x0000A5D0, followed directly by a control write of the stop word 0x00005AD0, disables the watchdog. The counter freezes and no reset is produced.
- R6: After an arm word, any write (to any address) other than the matching command word cancels the arm and has no other effect. A command word written without a preceding arm is ignored. An arm word always arms its own command, and it replaces any earlier arm.
- R7: With LOCKED=1, the stop arm word equals the start arm word. The stop sequence then has no effect, and a started watchdog cannot be stopped.
- R8: A tick that arrives while the watchdog is enabled and the counter is 0 disables the watchdog. The selected reset output then goes high for exactly PULSE_LEN (16) cycles, starting at that clock edge.
- R9: Bit 0 of the action register (address 1, read/write) selects the reset output at expiry: 0 selects core_rst_o and 1 selects bus_rst_o. The two outputs are never high together.
- R10: Bit 0 of the cause register (address 2) is set at expiry and stays set through the generated pulse. Only power-on reset clears it, or a write with bit 0 = 1. A write with bit 0 = 0 leaves it set.
- R11: Address 3 reads the counter value. Address 4 reads the state: bit 0 is enabled, bit 1 is start armed and bit 2 is stop armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| core_rst_o | output | 1 | Core reset pulse at expiry when the action bit is 0 |
| bus_rst_o | output | 1 | Bus-wide reset pulse at expiry when the action bit is 1 |

## Verification
Start and stop are tried with complete pairs, with arm words followed by writes to other addresses, with junk control words, with unarmed command words, and with one arm word replaced by another. These cases tell a true two-step check apart from a design that decodes single words or never clears the arm. Counting is tried with tick held high, with tick held low, with a keep-alive in mid-count and with a stop in mid-count, which separates reload from decrement and from hold. Expiry is run once with each action setting, and the pulse edges are sampled exactly, which catches off-by-one pulse lengths and the wrong output being chosen. The locked variant runs next to the normal one under the same stop attempts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ARM_NONE  = 2'd0,
    ARM_START = 2'd1,
    ARM_STOP  = 2'd2
  } arm_t;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ACTION = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATE  = 3'd4;
endpackage

// File: rtl/wdog_cmd_decode.sv
module wdog_cmd_decode
  import wdog_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter bit          LOCKED    = 1'b0,
  parameter logic [31:0] CODE_SARM = 32'h0000_A5E1,
  parameter logic [31:0] CODE_GO   = 32'h0000_5AE1,
  parameter logic [31:0] CODE_PARM = 32'h0000_A5D0,
  parameter logic [31:0] CODE_HALT = 32'h0000_5AD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              ctrl_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              start_cmd_o,
  output logic              stop_cmd_o,
  output arm_t              arm_o
);
  localparam logic [DATA_W-1:0] SARM_W = DATA_W'(CODE_SARM);
  localparam logic [DATA_W-1:0] GO_W   = DATA_W'(CODE_GO);
  localparam logic [DATA_W-1:0] PARM_W = LOCKED ? DATA_W'(CODE_SARM) : DATA_W'(CODE_PARM);
  localparam logic [DATA_W-1:0] HALT_W = DATA_W'(CODE_HALT);

  arm_t arm_q, arm_d;
  logic wr_ctrl;

  assign wr_ctrl = we_i && ctrl_sel_i;

  always_comb begin
    start_cmd_o = wr_ctrl && (arm_q == ARM_START) && (wdata_i == GO_W);
    stop_cmd_o  = wr_ctrl && (arm_q == ARM_STOP)  && (wdata_i == HALT_W);
    arm_d       = arm_q;
    if (we_i) begin
      if (wr_ctrl && wdata_i == SARM_W)      arm_d = ARM_START;
      else if (wr_ctrl && wdata_i == PARM_W) arm_d = ARM_STOP;
      else                                   arm_d = ARM_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     arm_q <= ARM_NONE;
    else if (we_i)  arm_q <= arm_d;
  end

  assign arm_o = arm_q;

  // R6
  cmd_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd_o |-> $past(we_i) && $past(ctrl_sel_i) && $past(wdata_i) == SARM_W);

  // R6
  arm_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !ctrl_sel_i) |=> arm_q == ARM_NONE);

  generate
    if (LOCKED) begin : g_locked
      // R7
      no_stop_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_cmd_o && arm_q != ARM_STOP);
    end
  endgenerate
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int              CNT_W    = 32,
  parameter logic [CNT_W-1:0] LOAD_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic             en_q, en_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    en_d     = en_q;
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (start_i) begin
      en_d  = 1'b1;
      cnt_d = LOAD_VAL;
    end else if (stop_i) begin
      en_d  = 1'b0;
    end else if (en_q && tick_i) begin
      if (cnt_q == '0) begin
        en_d     = 1'b0;
        expire_o = 1'b1;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  assign cnt_ce = start_i || stop_i || (en_q && tick_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (cnt_ce) begin
      en_q  <= en_d;
      cnt_q <= cnt_d;
    end
  end

  assign en_o  = en_q;
  assign cnt_o = cnt_q;

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (en_q && cnt_q == LOAD_VAL));

  // R3
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && tick_i && cnt_q != '0 && !start_i && !stop_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !start_i) |=> $stable(cnt_q));

  // R5
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !en_q);

  // R8
  expire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !en_q);
endmodule

// File: rtl/wdog_reset_ctl.sv
module wdog_reset_ctl #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic act_we_i,
  input  logic act_bit_i,
  input  logic cause_we_i,
  input  logic cause_bit_i,
  output logic action_o,
  output logic cause_o,
  output logic core_rst_o,
  output logic bus_rst_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] PLEN = PW'(PULSE_LEN);

  logic          act_q;
  logic          cause_q, cause_d;
  logic          sel_q;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pulse_on;

  assign pulse_on = (pcnt_q != '0);

  always_comb begin
    pcnt_d = pcnt_q;
    if (expire_i)      pcnt_d = PLEN;
    else if (pulse_on) pcnt_d = pcnt_q - PW'(1);
    cause_d = cause_q;
    if (expire_i)                      cause_d = 1'b1;
    else if (cause_we_i && cause_bit_i) cause_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      cause_q <= 1'b0;
      sel_q   <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      if (act_we_i)                        act_q   <= act_bit_i;
      if (expire_i || cause_we_i)          cause_q <= cause_d;
      if (expire_i)                        sel_q   <= act_q;
      if (expire_i || pulse_on)            pcnt_q  <= pcnt_d;
    end
  end

  assign action_o   = act_q;
  assign cause_o    = cause_q;
  assign core_rst_o = pulse_on && !sel_q;
  assign bus_rst_o  = pulse_on &&  sel_q;

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (core_rst_o || bus_rst_o));

  // R9
  one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_rst_o && bus_rst_o));

  // R9
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> (bus_rst_o == $past(act_q)));

  // R10
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> cause_q);

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q && !(cause_we_i && cause_bit_i)) |=> cause_q);
endmodule

// File: rtl/keepalive_wdog.sv
module keepalive_wdog
  import wdog_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] LOAD_VAL  = 32'hFFFF_FFFF,
  parameter int          PULSE_LEN = 16,
  parameter bit          LOCKED    = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              core_rst_o,
  output logic              bus_rst_o
);
  localparam logic [CNT_W-1:0] LOAD_C = CNT_W'(LOAD_VAL);

  logic             rst_meta, rst_ns;
  logic             start_cmd, stop_cmd, expire;
  arm_t             arm;
  logic             en;
  logic [CNT_W-1:0] cnt;
  logic             action, cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ns   <= rst_meta;
    end
  end

  wdog_cmd_decode #(
    .DATA_W (DATA_W),
    .LOCKED (LOCKED)
  ) u_dec (
    .clk         (clk),
    .rst_n       (rst_ns),
    .we_i        (we_i),
    .ctrl_sel_i  (addr_i == A_CTRL),
    .wdata_i     (wdata_i),
    .start_cmd_o (start_cmd),
    .stop_cmd_o  (stop_cmd),
    .arm_o       (arm)
  );

  wdog_counter #(
    .CNT_W    (CNT_W),
    .LOAD_VAL (LOAD_C)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .tick_i   (tick_i),
    .start_i  (start_cmd),
    .stop_i   (stop_cmd),
    .en_o     (en),
    .cnt_o    (cnt),
    .expire_o (expire)
  );

  wdog_reset_ctl #(
    .PULSE_LEN (PULSE_LEN)
  ) u_rst (
    .clk         (clk),
    .rst_n       (rst_ns),
    .expire_i    (expire),
    .act_we_i    (we_i && addr_i == A_ACTION),
    .act_bit_i   (wdata_i[0]),
    .cause_we_i  (we_i && addr_i == A_CAUSE),
    .cause_bit_i (wdata_i[0]),
    .action_o    (action),
    .cause_o     (cause),
    .core_rst_o  (core_rst_o),
    .bus_rst_o   (bus_rst_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_ACTION: rdata_o[0] = action;
      A_CAUSE:  rdata_o[0] = cause;
      A_COUNT:  rdata_o    = DATA_W'(cnt);
      A_STATE:  rdata_o[2:0] = {arm == ARM_STOP, arm == ARM_START, en};
      default:  rdata_o    = '0;
    endcase
  end
endmodule

// File: tb/keepalive_wdog_test.sv
module keepalive_wdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        we_a = 1'b0, we_b = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rd_a, rd_b;
  logic        core_a, bus_a, core_b, bus_b;
  int total = 0;
  int bad = 0;

  localparam logic [31:0] SARM = 32'h0000_A5E1, GO = 32'h0000_5AE1;
  localparam logic [31:0] PARM = 32'h0000_A5D0, HALT = 32'h0000_5AD0;
  localparam int LOAD = 20;

  always #10 clk = ~clk;

  keepalive_wdog #(.LOAD_VAL(32'd20), .LOCKED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .we_i(we_a), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_a), .core_rst_o(core_a), .bus_rst_o(bus_a));

  keepalive_wdog #(.LOAD_VAL(32'd1000), .LOCKED(1'b1)) uut_lock (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .we_i(we_b), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rd_b), .core_rst_o(core_b), .bus_rst_o(bus_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit lk, input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d;
    if (lk) we_b = 1'b1; else we_a = 1'b1;
    @(negedge clk);
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(input bit lk, input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = lk ? rd_b : rd_a;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, 3'd3, v); chk("R1 count", v, 0);
    rd(0, 3'd4, v); chk("R1 state", v, 0);
    rd(0, 3'd1, v); chk("R1 action", v, 0);
    rd(0, 3'd2, v); chk("R1 cause", v, 0);
    chk("R1 outputs", {core_a, bus_a}, 0);
  endtask

  task automatic t_start_count;
    logic [31:0] v;
    wr(0, 3'd0, SARM);
    rd(0, 3'd4, v); chk("R11 start armed", v, 32'h2);
    wr(0, 3'd0, GO);
    rd(0, 3'd3, v); chk("R2 load", v, LOAD);
    rd(0, 3'd4, v); chk("R2 enabled", v, 1);
    step(4);
    rd(0, 3'd3, v); chk("R3 decrement", v, LOAD - 4);
    tick = 1'b0; step(5);
    rd(0, 3'd3, v); chk("R3 hold without tick", v, LOAD - 4);
    tick = 1'b1;
  endtask

  task automatic t_keepalive;
    logic [31:0] v;
    step(3);
    wr(0, 3'd0, SARM);
    wr(0, 3'd0, GO);
    rd(0, 3'd3, v); chk("R4 reload", v, LOAD);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    step(3);
    wr(0, 3'd0, PARM);
    rd(0, 3'd4, v); chk("R11 stop armed", v, 32'h5);
    wr(0, 3'd0, HALT);
    rd(0, 3'd4, v); chk("R5 disabled", v, 0);
    rd(0, 3'd3, v); chk("R5 frozen value", v, LOAD - 4);
    step(LOAD + 5);
    rd(0, 3'd3, v); chk("R5 still frozen", v, LOAD - 4);
    chk("R5 no reset", {core_a, bus_a}, 0);
  endtask

  task automatic t_cancel;
    logic [31:0] v;
    wr(0, 3'd0, SARM);
    wr(0, 3'd1, 32'd0);
    rd(0, 3'd4, v); chk("R6 arm cancelled by other address", v, 0);
    wr(0, 3'd0, GO);
    rd(0, 3'd4, v); chk("R6 unarmed start ignored", v, 0);
    rd(0, 3'd1, v); chk("R6 cancel write kept action", v, 0);
    wr(0, 3'd0, SARM);
    wr(0, 3'd0, 32'h1234);
    wr(0, 3'd0, GO);
    rd(0, 3'd4, v); chk("R6 junk cancels arm", v, 0);
    wr(0, 3'd0, SARM);
    wr(0, 3'd0, PARM);
    rd(0, 3'd4, v); chk("R6 arm replaced", v, 32'h4);
    wr(0, 3'd0, GO);
    rd(0, 3'd4, v); chk("R6 mismatched command ignored", v, 0);
    rd(0, 3'd3, v); chk("R6 count untouched", v, LOAD - 4);
  endtask

  task automatic t_locked;
    logic [31:0] v;
    wr(1, 3'd0, SARM);
    wr(1, 3'd0, GO);
    rd(1, 3'd4, v); chk("R7 locked started", v, 1);
    wr(1, 3'd0, PARM);
    wr(1, 3'd0, HALT);
    rd(1, 3'd4, v); chk("R7 stop pair ignored", v, 1);
    wr(1, 3'd0, SARM);
    wr(1, 3'd0, HALT);
    rd(1, 3'd4, v); chk("R7 shared arm cannot stop", v, 1);
  endtask

  task automatic t_expire(input bit use_bus);
    logic [31:0] v;
    wr(0, 3'd1, {31'd0, use_bus});
    wr(0, 3'd0, SARM);
    wr(0, 3'd0, GO);
    step(LOAD);
    rd(0, 3'd3, v); chk("R8 reached zero", v, 0);
    chk("R8 no pulse before expiry", {core_a, bus_a}, 0);
    step(1);
    chk("R9 selected output", {core_a, bus_a}, use_bus ? 2'b01 : 2'b10);
    rd(0, 3'd4, v); chk("R8 disabled at expiry", v, 0);
    step(PULSE_LEN_M1);
    chk("R8 pulse last cycle", {core_a, bus_a}, use_bus ? 2'b01 : 2'b10);
    step(1);
    chk("R8 pulse ended", {core_a, bus_a}, 0);
    rd(0, 3'd2, v); chk("R10 cause survives pulse", v, 1);
  endtask
  localparam int PULSE_LEN_M1 = 15;

  task automatic t_cause;
    logic [31:0] v;
    wr(0, 3'd2, 32'd0);
    rd(0, 3'd2, v); chk("R10 write 0 keeps cause", v, 1);
    wr(0, 3'd2, 32'd1);
    rd(0, 3'd2, v); chk("R10 write 1 clears cause", v, 0);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 outputs in reset", {core_a, bus_a}, 0);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_start_count();
    t_keepalive();
    t_stop();
    t_cancel();
    t_locked();
    t_expire(1'b0);
    t_cause();
    t_expire(1'b1);
    rd(0, 3'd1, wdata); chk("R9 action readback", wdata, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule